// File: doc/BRIEF.md
# NRZ Magnetic Track Bit Codec

This block sits between a serial bit stream and a magnetic recording track that stores non-return-to-zero levels but gives back only flux changes. On the write side it turns each accepted bit into a two-state head current direction. That direction is held for the whole bit cell and is never left undriven. On the read side it takes the sign of the sensed flux change: a rising pulse, a falling pulse, or nothing. It samples this once per cell on a strobe and rebuilds the bit stream by remembering the last level through cells that carry no pulse.

Every recorded word opens with a synchronizing bit cell. A strobe flagged as that cell sets the decoder level to 0 and produces no output bit. Each later strobed cell yields one output bit, one clock after the strobe. A pulse whose sign does not match the current level, or a cell that shows both signs at once, sets a sticky polarity-error flag. The write side uses a valid/ready handshake. `wr_ready` is high only in the one clock per cell marked by `cell_tick`. A source that keeps `wr_valid` high waits for that clock. When no bit is offered in a cell, the previous direction is kept. The read side has no ready input, because the track cannot be paused. Whatever consumes the data must take the bit in every clock where `rd_valid` is high.

Top module: `nrz_track_codec`

## Requirements
- R1: A write bit is accepted when `wr_valid` and `wr_ready` are both high at a rising clock edge, and `wr_dir` equals that bit from the next clock on (1 = direction for a one, 0 = direction for a zero).
- R2: When no bit is accepted at an edge, `wr_dir` keeps its value.
- R3: `wr_ready` is high exactly in the clocks where `cell_tick` is high. `wr_valid` without `cell_tick` changes nothing.
- R4: A strobed data cell (`rd_strobe` high, `rd_sync` low) with only `pulse_pos` high gives `rd_data` = 1 with `rd_valid` high in the next clock.
- R5: A strobed data cell with only `pulse_neg` high gives `rd_data` = 0 with `rd_valid` high in the next clock.
- R6: A strobed data cell with no pulse gives `rd_valid` high in the next clock with `rd_data` unchanged from the previous decoded bit.
- R7: Pulse inputs seen while `rd_strobe` is low have no effect on `rd_data`, `rd_valid` or `pol_err`.
- R8: A strobe with `rd_sync` high sets `rd_data` to 0, ignores the pulse inputs, and leaves `rd_valid` low in the next clock.
- R9: A positive pulse while `rd_data` is 1, or a negative pulse while it is 0, sets `pol_err`. The level still follows the pulse sign.
- R10: A strobed data cell with both pulse inputs high sets `pol_err` and keeps `rd_data` unchanged, while still giving `rd_valid`.
- R11: Once set, `pol_err` stays high until reset, across later data and sync cells.
- R12: While `rst_n` is low, and in the first clock after it is released, `wr_dir`, `rd_data`, `rd_valid` and `pol_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_tick | input | 1 | One-clock marker of a write bit cell boundary |
| wr_valid | input | 1 | Write bit offered |
| wr_data | input | 1 | Write bit value |
| wr_ready | output | 1 | Write bit taken this clock |
| wr_dir | output | 1 | Head current direction level (1 = one, 0 = zero) |
| rd_strobe | input | 1 | Per-cell read sampling window |
| rd_sync | input | 1 | Marks the strobed cell as the word's synchronizing bit |
| pulse_pos | input | 1 | Positive flux-change pulse detected |
| pulse_neg | input | 1 | Negative flux-change pulse detected |
| rd_valid | output | 1 | Recovered bit present on rd_data |
| rd_data | output | 1 | Recovered bit level |
| pol_err | output | 1 | Sticky polarity error |

## Verification
The hardest situation to reach is a pulse whose sign contradicts the held level. A track written consistently never produces one, and the level that decides the outcome is several cells in the past. The stimulus builds its pulse stream from a bit pattern, the way a head would, and then adds deliberate sign faults at known levels: right after a sync cell, after a run of pulse-free cells, and with both signs at once. The error flag is then followed through later sync and data cells to show that it stays set.

// File: rtl/nrz_track_pkg.sv
package nrz_track_pkg;
  typedef enum logic [1:0] {
    PK_NONE = 2'b00,
    PK_RISE = 2'b01,
    PK_FALL = 2'b10,
    PK_BOTH = 2'b11
  } pulse_kind_e;

  function automatic pulse_kind_e classify(input logic pos, input logic neg);
    return pulse_kind_e'({neg, pos});
  endfunction
endpackage

// File: rtl/nrz_write_drv.sv
module nrz_write_drv #(
  parameter logic RESET_DIR = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cell_tick,
  input  logic bit_valid,
  input  logic bit_data,
  output logic bit_ready,
  output logic head_dir
);
  logic take;

  assign bit_ready = cell_tick;
  assign take      = bit_valid & cell_tick;

  always_ff @(posedge clk) begin
    if (!rst_n)    head_dir <= RESET_DIR;
    else if (take) head_dir <= bit_data;
  end
endmodule

// File: rtl/nrz_pulse_sampler.sv
module nrz_pulse_sampler
  import nrz_track_pkg::*;
(
  input  logic        strobe,
  input  logic        sync_cell,
  input  logic        pos,
  input  logic        neg,
  output logic        data_cell,
  output logic        init_cell,
  output pulse_kind_e kind
);
  assign data_cell = strobe & ~sync_cell;
  assign init_cell = strobe & sync_cell;
  assign kind      = data_cell ? classify(pos, neg) : PK_NONE;
endmodule

// File: rtl/nrz_level_decoder.sv
module nrz_level_decoder
  import nrz_track_pkg::*;
#(
  parameter logic SYNC_LEVEL = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        data_cell,
  input  logic        init_cell,
  input  pulse_kind_e kind,
  output logic        level,
  output logic        level_valid,
  output logic        err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level       <= SYNC_LEVEL;
      level_valid <= 1'b0;
      err         <= 1'b0;
    end else begin
      level_valid <= data_cell;
      if (init_cell) begin
        level <= SYNC_LEVEL;
      end else if (data_cell) begin
        unique case (kind)
          PK_RISE: begin
            if (level) err <= 1'b1;
            level <= 1'b1;
          end
          PK_FALL: begin
            if (!level) err <= 1'b1;
            level <= 1'b0;
          end
          PK_BOTH: err <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/nrz_track_codec.sv
module nrz_track_codec
  import nrz_track_pkg::*;
#(
  parameter logic RESET_DIR  = 1'b0,
  parameter logic SYNC_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cell_tick,
  input  logic wr_valid,
  input  logic wr_data,
  output logic wr_ready,
  output logic wr_dir,
  input  logic rd_strobe,
  input  logic rd_sync,
  input  logic pulse_pos,
  input  logic pulse_neg,
  output logic rd_valid,
  output logic rd_data,
  output logic pol_err
);
  logic        data_cell;
  logic        init_cell;
  pulse_kind_e kind;

  nrz_write_drv #(.RESET_DIR(RESET_DIR)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cell_tick (cell_tick),
    .bit_valid (wr_valid),
    .bit_data  (wr_data),
    .bit_ready (wr_ready),
    .head_dir  (wr_dir)
  );

  nrz_pulse_sampler u_smp (
    .strobe    (rd_strobe),
    .sync_cell (rd_sync),
    .pos       (pulse_pos),
    .neg       (pulse_neg),
    .data_cell (data_cell),
    .init_cell (init_cell),
    .kind      (kind)
  );

  nrz_level_decoder #(.SYNC_LEVEL(SYNC_LEVEL)) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_cell   (data_cell),
    .init_cell   (init_cell),
    .kind        (kind),
    .level       (rd_data),
    .level_valid (rd_valid),
    .err         (pol_err)
  );
endmodule

// File: rtl/nrz_track_codec_chk.sv
module nrz_track_codec_chk (
  input logic clk,
  input logic rst_n,
  input logic cell_tick,
  input logic wr_valid,
  input logic wr_data,
  input logic wr_ready,
  input logic wr_dir,
  input logic rd_strobe,
  input logic rd_sync,
  input logic pulse_pos,
  input logic pulse_neg,
  input logic rd_valid,
  input logic rd_data,
  input logic pol_err
);
  // R1
  wr_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && cell_tick) |=> (wr_dir == $past(wr_data)));
  // R2
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_ready) |=> $stable(wr_dir));
  // R4
  rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !rd_sync && pulse_pos && !pulse_neg) |=> (rd_valid && rd_data));
  // R5
  fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !rd_sync && pulse_neg && !pulse_pos) |=> (rd_valid && !rd_data));
  // R6
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !rd_sync && !pulse_pos && !pulse_neg) |=> (rd_valid && $stable(rd_data)));
  // R7
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_strobe && !rd_sync));
  // R8
  sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && rd_sync) |=> (!rd_valid && !rd_data));
  // R9
  sign_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !rd_sync && ((pulse_pos && rd_data) || (pulse_neg && !rd_data))) |=> pol_err);
  // R10
  both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !rd_sync && pulse_pos && pulse_neg) |=> (pol_err && $stable(rd_data)));
  // R11
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pol_err |=> pol_err);
endmodule

bind nrz_track_codec nrz_track_codec_chk u_chk (.*);

// File: tb/test_nrz_track_codec.sv
`timescale 1ns/1ps
module test_nrz_track_codec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cell_tick = 1'b0, wr_valid = 1'b0, wr_data = 1'b0;
  logic rd_strobe = 1'b0, rd_sync = 1'b0, pulse_pos = 1'b0, pulse_neg = 1'b0;
  logic wr_ready, wr_dir, rd_valid, rd_data, pol_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit exp_q[$];
  string tag_q[$];
  bit m_lvl = 1'b0;
  bit m_err = 1'b0;

  always #4 clk = ~clk;

  nrz_track_codec i_nrz_track_codec (
    .clk(clk), .rst_n(rst_n), .cell_tick(cell_tick), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ready(wr_ready), .wr_dir(wr_dir),
    .rd_strobe(rd_strobe), .rd_sync(rd_sync), .pulse_pos(pulse_pos),
    .pulse_neg(pulse_neg), .rd_valid(rd_valid), .rd_data(rd_data),
    .pol_err(pol_err)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // monitor: pops expected read bits as the design delivers them
  always @(negedge clk) begin
    if (rst_n && rd_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7: actual rd_valid 1 expected 0 (no cell pending)");
      end else begin
        string t;
        bit e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, rd_data, e);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 wr_dir", wr_dir, 1'b0);
    chk("R12 rd_data", rd_data, 1'b0);
    chk("R12 rd_valid", rd_valid, 1'b0);
    chk("R12 pol_err", pol_err, 1'b0);
    rst_n = 1'b1;
    m_lvl = 1'b0;
    m_err = 1'b0;
    @(negedge clk);
    chk("R12 rd_valid post", rd_valid, 1'b0);
    chk("R12 pol_err post", pol_err, 1'b0);
  endtask

  // driver: one read cell; pushes the expected bit into the scoreboard
  task automatic rcell(input bit pos, input bit neg, input bit sync, input string tag);
    @(negedge clk);
    rd_strobe = 1'b1; rd_sync = sync; pulse_pos = pos; pulse_neg = neg;
    if (sync) m_lvl = 1'b0;
    else begin
      if (pos && neg) m_err = 1'b1;
      else if (pos) begin if (m_lvl) m_err = 1'b1; m_lvl = 1'b1; end
      else if (neg) begin if (!m_lvl) m_err = 1'b1; m_lvl = 1'b0; end
      exp_q.push_back(m_lvl);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    rd_strobe = 1'b0; rd_sync = 1'b0; pulse_pos = 1'b0; pulse_neg = 1'b0;
  endtask

  task automatic wbit(input bit v, input bit d, input bit tick, input bit exp_dir, input string tag);
    @(negedge clk);
    wr_valid = v; wr_data = d; cell_tick = tick;
    #1 chk("R3 wr_ready", wr_ready, tick);
    @(negedge clk);
    wr_valid = 1'b0; cell_tick = 1'b0;
    chk(tag, wr_dir, exp_dir);
  endtask

  initial begin
    bit pat[12] = '{1,1,0,1,0,0,0,1,1,1,0,1};
    bit prev;
    do_reset();

    // write side
    wbit(1, 1, 1, 1'b1, "R1 write one");
    wbit(1, 0, 0, 1'b1, "R3 valid without tick");
    wbit(0, 0, 1, 1'b1, "R2 tick without valid");
    wbit(1, 0, 1, 1'b0, "R1 write zero");
    repeat (3) begin
      @(negedge clk);
      chk("R2 idle hold", wr_dir, 1'b0);
    end

    // round trip: pulses derived from a bit pattern as a head would see them
    rcell(0, 0, 1, "R8");
    chk("R8 sync level", rd_data, 1'b0);
    prev = 1'b0;
    for (int i = 0; i < 12; i++) begin
      bit p, n;
      p = pat[i] & ~prev;
      n = ~pat[i] & prev;
      prev = pat[i];
      rcell(p, n, 0, p ? "R4 rise" : (n ? "R5 fall" : "R6 hold"));
    end
    chk("R9 no error on clean stream", pol_err, 1'b0);

    // pulses outside the strobe are ignored
    @(negedge clk);
    pulse_neg = 1'b1;
    @(negedge clk);
    pulse_neg = 1'b0; pulse_pos = 1'b1;
    @(negedge clk);
    pulse_pos = 1'b0;
    chk("R7 level untouched", rd_data, 1'b1);
    chk("R7 no error", pol_err, 1'b0);
    rcell(0, 0, 0, "R6 after stray pulses");

    // sync ignores pulses and zeroes the level
    rcell(1, 0, 1, "R8");
    chk("R8 sync with pulse", rd_data, 1'b0);
    rcell(0, 0, 0, "R6 after sync");

    // sign fault: falling pulse at level 0
    rcell(0, 1, 0, "R9 fall at zero");
    chk("R9 flag set", pol_err, 1'b1);
    rcell(1, 0, 0, "R4 rise after fault");
    rcell(0, 0, 1, "R8");
    chk("R11 sticky across sync", pol_err, 1'b1);
    rcell(0, 0, 0, "R6 post sync");
    chk("R11 sticky across data", pol_err, 1'b1);

    // sign fault: rising pulse at level 1
    do_reset();
    rcell(1, 0, 0, "R4 rise");
    rcell(0, 0, 0, "R6 hold");
    chk("R9 clean before fault", pol_err, 1'b0);
    rcell(1, 0, 0, "R9 rise at one");
    chk("R9 flag set at one", pol_err, 1'b1);

    // both signs in one cell
    do_reset();
    rcell(1, 0, 0, "R4 rise");
    rcell(1, 1, 0, "R10 both held");
    chk("R10 flag", pol_err, 1'b1);
    chk("R10 level", rd_data, 1'b1);

    repeat (3) @(negedge clk);
    chk("R6 scoreboard drained", exp_q.size() == 0, 1'b1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 50000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule